// File: doc/BRIEF.md
# Video Sync Port Controller

This block manages the two bidirectional reference pins of a digital video encoder. Each pin can act as an output or an input. Pin one, when it drives, carries one of three vertical timing signals:

- a vertical sync on every field,
- an odd/even frame indicator,
- a field-sequence pulse that repeats after a number of fields set by the colour standard.

Pin two, when it drives, carries a horizontal reference window set by programmed start and end pixel counts. A blanking-select bit can gate that window so it appears only on active lines.

When a pin is an input, its signal passes through a two-flop synchronizer. An edge detector then turns the chosen active edge into a one-clock strobe for the timing generator. A source bit and an embedded-sync mode bit decide where horizontal sync comes from. Pin two as an input can also supply an external blanking level.

An internal timing generator supplies the pixel count, the line count, a line-start strobe, the vertical sync level and the odd/even field level. The block counts fields itself, at the end of each vertical sync pulse. Direction and polarity settings are loaded only on a line-start cycle, so each pin changes direction only on a line boundary.

Top module: `vsync_port_ctrl`

## Requirements
- R1: After reset both pins are inputs (`p1_oe`=0, `p2_oe`=0), both pin outputs are 0, all strobes are 0, and the field counter is 0.
- R2: The pin-one type select is `cfg[1:0]`. 00 drives the vertical sync level, 01 drives the odd/even field level, and 11 drives a constant inactive level. The pin output is registered: it follows its inputs one clock later.
- R3: With select 10, pin one drives the vertical sync level only while the field counter is 0. The counter advances at the end of each vertical sync pulse and wraps after 4 fields (NTSC-type), 8 fields (`std_pal`=1) or 12 fields (`std_secam`=1, which wins over `std_pal`).
- R4: After any change of standard, the end of the next vertical sync pulse sets the field counter to 0 instead of advancing it.
- R5: A polarity bit inverts the driven level of each pin: `cfg[3]` for pin one and `cfg[5]` for pin two. A value of 1 gives active-low.
- R6: The direction bits (`cfg[2]` for pin one, `cfg[4]` for pin two, 1 = output) and both polarity bits take effect only in the cycle after `line_start` is high. At any other time a change in `cfg` does not change `p1_oe` or `p2_oe`.
- R7: With `cfg[7]`=0, pin two is active while `h_start` <= `pix_cnt` < `h_end`, on every line regardless of `line_cnt`.
- R8: With `cfg[7]`=1, pin two is active only when the R7 window holds and `line_first` <= `line_cnt` <= `line_last`. It stays inactive on all other lines.
- R9: An input pin produces a one-clock strobe on its rising edge when its polarity bit is 0, and on its falling edge when it is 1. The strobe appears two clocks after the pin changes.
- R10: Horizontal sync strobe source:
  - With `emb_mode`=1 and `hs_src`=0, `hs_strobe` follows `emb_fs`.
  - With `emb_mode`=0 and `hs_src`=0, it comes from pin-one edges.
  - With `emb_mode`=0 and `hs_src`=1, it comes from pin-two edges, but only if the enable bit `cfg[6]` is 1.
- R11: With `emb_mode`=0 and `hs_src`=1, pin-one edges drive `vs_strobe`.
- R12: With pin two an input, `cfg[7]`=1 and `emb_mode`=0, `blank_ext` gives the synchronized active level of pin two, according to its polarity, two clocks after the pin changes.
- R13: A pin configured as an output produces no edge strobe, whatever level appears on its input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 8 | Configuration byte (fields listed in the requirements) |
| hs_src | input | 1 | Horizontal sync source: 0 = pin one or embedded sync, 1 = pin two |
| emb_mode | input | 1 | Embedded-sync mode |
| std_pal | input | 1 | 8-field sequence standard |
| std_secam | input | 1 | 12-field sequence standard |
| h_start | input | PIX_W | First pixel of the horizontal window |
| h_end | input | PIX_W | Pixel just after the horizontal window |
| line_first | input | LINE_W | First active line |
| line_last | input | LINE_W | Last active line |
| pix_cnt | input | PIX_W | Pixel count from the timing generator |
| line_cnt | input | LINE_W | Line count from the timing generator |
| line_start | input | 1 | Line boundary strobe |
| vs_level | input | 1 | Vertical sync level from the timing generator |
| field_odd | input | 1 | Odd/even field level |
| emb_fs | input | 1 | Decoded embedded frame-sync strobe |
| p1_in | input | 1 | Pin one input level |
| p1_out | output | 1 | Pin one driven level |
| p1_oe | output | 1 | Pin one output enable |
| p2_in | input | 1 | Pin two input level |
| p2_out | output | 1 | Pin two driven level |
| p2_oe | output | 1 | Pin two output enable |
| hs_strobe | output | 1 | Horizontal sync strobe to the timing generator |
| vs_strobe | output | 1 | Vertical sync strobe to the timing generator |
| blank_ext | output | 1 | External blanking level |

## Verification
The bench builds the block with `PIX_W`=8 and `LINE_W`=6. With these narrow counters, window edges and active-line limits can be placed at chosen values and reached in a few cycles.

The bench runs enough vertical sync pulses to cover the full 4-, 8- and 12-field sequences. It also changes the standard part-way through a sequence, so the restart at zero is checked against a counter that is not at zero.

// File: rtl/vsync_port_ctrl.sv
module vsync_port_ctrl #(
  parameter int PIX_W  = 12,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg,
  input  logic              hs_src,
  input  logic              emb_mode,
  input  logic              std_pal,
  input  logic              std_secam,
  input  logic [PIX_W-1:0]  h_start,
  input  logic [PIX_W-1:0]  h_end,
  input  logic [LINE_W-1:0] line_first,
  input  logic [LINE_W-1:0] line_last,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              line_start,
  input  logic              vs_level,
  input  logic              field_odd,
  input  logic              emb_fs,
  input  logic              p1_in,
  output logic              p1_out,
  output logic              p1_oe,
  input  logic              p2_in,
  output logic              p2_out,
  output logic              p2_oe,
  output logic              hs_strobe,
  output logic              vs_strobe,
  output logic              blank_ext
);

  localparam int FC_W = 4;

  logic [1:0] p1_sel;
  logic       p2_hen, p2_blk;
  assign p1_sel = cfg[1:0];
  assign p2_hen = cfg[6];
  assign p2_blk = cfg[7];

  // direction and polarity, loaded on line boundaries
  logic p1_oe_q, p1_pol_q, p2_oe_q, p2_pol_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p1_oe_q <= 1'b0; p1_pol_q <= 1'b0;
      p2_oe_q <= 1'b0; p2_pol_q <= 1'b0;
    end else if (line_start) begin
      p1_oe_q <= cfg[2]; p1_pol_q <= cfg[3];
      p2_oe_q <= cfg[4]; p2_pol_q <= cfg[5];
    end

  assign p1_oe = p1_oe_q;
  assign p2_oe = p2_oe_q;

  // input synchronizers with one extra stage for edge detection
  logic [2:0] p1_sh, p2_sh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p1_sh <= '0;
      p2_sh <= '0;
    end else begin
      p1_sh <= {p1_sh[1:0], p1_in};
      p2_sh <= {p2_sh[1:0], p2_in};
    end

  logic p1_edge, p2_edge;
  assign p1_edge = !p1_oe_q && (p1_pol_q ? (p1_sh[2] & ~p1_sh[1]) : (p1_sh[1] & ~p1_sh[2]));
  assign p2_edge = !p2_oe_q && (p2_pol_q ? (p2_sh[2] & ~p2_sh[1]) : (p2_sh[1] & ~p2_sh[2]));

  assign hs_strobe = emb_mode ? (!hs_src && emb_fs)
                              : (hs_src ? (p2_edge && p2_hen) : p1_edge);
  assign vs_strobe = !emb_mode && hs_src && p1_edge;
  assign blank_ext = !emb_mode && p2_blk && !p2_oe_q && (p2_sh[1] ^ p2_pol_q);

  // field sequence counter
  logic            vs_q;
  logic [FC_W-1:0] fcnt, flen;
  logic [1:0]      std_q, std_now;
  logic            vs_fall, std_chg;

  assign std_now = {std_secam, std_pal};
  assign flen    = std_secam ? FC_W'(12) : (std_pal ? FC_W'(8) : FC_W'(4));
  assign vs_fall = vs_q && !vs_level;
  assign std_chg = std_now != std_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      vs_q  <= 1'b0;
      fcnt  <= '0;
      std_q <= '0;
    end else begin
      vs_q <= vs_level;
      if (vs_fall) begin
        std_q <= std_now;
        if (std_chg || fcnt >= flen - FC_W'(1)) fcnt <= '0;
        else                                     fcnt <= fcnt + FC_W'(1);
      end
    end

  // driven levels, registered after polarity
  logic p1_lvl, p2_lvl, href, in_act;
  always_comb
    case (p1_sel)
      2'b00:   p1_lvl = vs_level;
      2'b01:   p1_lvl = field_odd;
      2'b10:   p1_lvl = vs_level && (fcnt == '0);
      default: p1_lvl = 1'b0;
    endcase

  assign href   = (pix_cnt >= h_start) && (pix_cnt < h_end);
  assign in_act = (line_cnt >= line_first) && (line_cnt <= line_last);
  assign p2_lvl = href && (!p2_blk || in_act);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      p1_out <= 1'b0;
      p2_out <= 1'b0;
    end else begin
      p1_out <= p1_lvl ^ p1_pol_q;
      p2_out <= p2_lvl ^ p2_pol_q;
    end

  p_oe_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(p1_oe) || !$stable(p2_oe)) |-> $past(line_start));

  p_edge_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    p1_edge |=> !p1_edge);

  p_fcnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_fall && !std_chg) |=> (fcnt == '0 || fcnt == $past(fcnt) + FC_W'(1)));

  p_std_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vs_fall && std_chg) |=> (fcnt == '0));

  p_blank_sup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_blk && !p2_pol_q && !in_act) |=> !p2_out);

  p_out_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_oe && p2_oe && !emb_mode) |-> (!hs_strobe && !vs_strobe));

endmodule

// File: tb/vsync_port_ctrl_tb.sv
`timescale 1ns/1ps
module vsync_port_ctrl_tb;
  localparam int PW = 8;
  localparam int LW = 6;

  logic clk = 0, rst_n = 0;
  logic [7:0] cfg = 0;
  logic hs_src = 0, emb_mode = 0, std_pal = 0, std_secam = 0;
  logic [PW-1:0] h_start = 10, h_end = 20, pix_cnt = 0;
  logic [LW-1:0] line_first = 20, line_last = 30, line_cnt = 0;
  logic line_start = 0, vs_level = 0, field_odd = 0, emb_fs = 0;
  logic p1_in = 0, p2_in = 0;
  logic p1_out, p1_oe, p2_out, p2_oe, hs_strobe, vs_strobe, blank_ext;

  vsync_port_ctrl #(.PIX_W(PW), .LINE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .hs_src(hs_src), .emb_mode(emb_mode),
    .std_pal(std_pal), .std_secam(std_secam), .h_start(h_start), .h_end(h_end),
    .line_first(line_first), .line_last(line_last), .pix_cnt(pix_cnt),
    .line_cnt(line_cnt), .line_start(line_start), .vs_level(vs_level),
    .field_odd(field_odd), .emb_fs(emb_fs), .p1_in(p1_in), .p1_out(p1_out),
    .p1_oe(p1_oe), .p2_in(p2_in), .p2_out(p2_out), .p2_oe(p2_oe),
    .hs_strobe(hs_strobe), .vs_strobe(vs_strobe), .blank_ext(blank_ext));

  always #2 clk = ~clk;

  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int sig; bit exp; string tag; } item_t;
  item_t q[$];

  function automatic bit get_sig(int s);
    case (s)
      0: return p1_out;   1: return p2_out;   2: return p1_oe;  3: return p2_oe;
      4: return hs_strobe; 5: return vs_strobe; default: return blank_ext;
    endcase
  endfunction

  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        n_chk++;
        if (get_sig(q[i].sig) !== q[i].exp) begin
          n_fail++;
          $display("FAIL %s sig%0d cycle %0d: actual %0b expected %0b",
                   q[i].tag, q[i].sig, cyc, get_sig(q[i].sig), q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic expect_at(int dly, int sig, bit v, string tag);
    item_t it;
    it.due = cyc + dly; it.sig = sig; it.exp = v; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic set_cfg(logic [7:0] v);
    cfg = v; line_start = 1; tick(); line_start = 0;
  endtask

  task automatic vs_pulse(bit exp, string tag);
    vs_level = 1; expect_at(1, 0, exp, tag); tick();
    vs_level = 0; expect_at(1, 0, 0, tag); tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(2);
    expect_at(1, 2, 0, "R1"); expect_at(1, 3, 0, "R1");
    expect_at(1, 0, 0, "R1"); expect_at(1, 1, 0, "R1");
    expect_at(1, 4, 0, "R1"); expect_at(1, 5, 0, "R1"); expect_at(1, 6, 0, "R1");
    tick(2);
    rst_n = 1; tick(2);

    // R6: cfg change without a line boundary is not taken
    cfg = 8'h14; expect_at(1, 2, 0, "R6"); expect_at(2, 2, 0, "R6");
    expect_at(2, 3, 0, "R6"); tick(3);
    line_start = 1; expect_at(1, 2, 1, "R6"); expect_at(1, 3, 1, "R6"); tick();
    line_start = 0;

    // R3: 4-field sequence, counter starts at 0 after reset (R1)
    set_cfg(8'h06);
    for (int k = 0; k < 9; k++) vs_pulse(k % 4 == 0, "R3");
    // R4 + R3: switch to 8-field standard with counter at 1
    std_pal = 1; tick();
    for (int k = 0; k < 10; k++) vs_pulse(k == 1 || k == 9, "R4");
    // 12-field standard wins over 8-field
    std_secam = 1; tick();
    for (int k = 0; k < 15; k++) vs_pulse(k == 1 || k == 13, "R3");

    // R2 selects
    set_cfg(8'h04);
    vs_level = 1; expect_at(1, 0, 1, "R2"); tick();
    vs_level = 0; expect_at(1, 0, 0, "R2"); tick();
    set_cfg(8'h05);
    field_odd = 1; expect_at(1, 0, 1, "R2"); tick();
    field_odd = 0; expect_at(1, 0, 0, "R2"); tick();
    set_cfg(8'h07);
    vs_level = 1; field_odd = 1; expect_at(1, 0, 0, "R2"); tick();
    vs_level = 0; field_odd = 0; tick();
    // R5 on pin one
    set_cfg(8'h0C);
    expect_at(1, 0, 1, "R5"); tick();
    vs_level = 1; expect_at(1, 0, 0, "R5"); tick();
    vs_level = 0; tick();

    // R7 window on every line
    set_cfg(8'h10); line_cnt = 5;
    pix_cnt = 9;  expect_at(1, 1, 0, "R7"); tick();
    pix_cnt = 10; expect_at(1, 1, 1, "R7"); tick();
    pix_cnt = 19; expect_at(1, 1, 1, "R7"); tick();
    pix_cnt = 20; expect_at(1, 1, 0, "R7"); tick();
    // R8 active lines only
    set_cfg(8'h90); pix_cnt = 12;
    line_cnt = 5;  expect_at(1, 1, 0, "R8"); tick();
    line_cnt = 20; expect_at(1, 1, 1, "R8"); tick();
    line_cnt = 30; expect_at(1, 1, 1, "R8"); tick();
    line_cnt = 31; expect_at(1, 1, 0, "R8"); tick();
    // R5 on pin two
    set_cfg(8'hB0); line_cnt = 25;
    expect_at(1, 1, 0, "R5"); tick();
    pix_cnt = 5; expect_at(1, 1, 1, "R5"); tick();

    // R9/R10: pin one input, rising edge
    set_cfg(8'h00); tick(4);
    p1_in = 1; expect_at(1, 4, 0, "R9"); expect_at(2, 4, 1, "R9");
    expect_at(3, 4, 0, "R9"); tick(4);
    p1_in = 0; expect_at(2, 4, 0, "R9"); tick(4);
    // R9 falling edge
    set_cfg(8'h08); tick(4);
    p1_in = 1; expect_at(2, 4, 0, "R9"); tick(4);
    p1_in = 0; expect_at(2, 4, 1, "R9"); expect_at(3, 4, 0, "R9"); tick(4);
    // R10 embedded source
    set_cfg(8'h00); emb_mode = 1;
    emb_fs = 1; expect_at(1, 4, 1, "R10"); tick();
    emb_fs = 0; expect_at(1, 4, 0, "R10"); tick();
    emb_mode = 0;
    // R10 pin two source with enable, R11 pin one to vertical strobe
    set_cfg(8'h40); hs_src = 1; tick(4);
    p2_in = 1; expect_at(2, 4, 1, "R10"); expect_at(2, 5, 0, "R11"); tick(4);
    p1_in = 1; expect_at(2, 5, 1, "R11"); expect_at(2, 4, 0, "R11");
    expect_at(3, 5, 0, "R11"); tick(4);
    p1_in = 0; p2_in = 0; tick(4);
    set_cfg(8'h00);
    p2_in = 1; expect_at(2, 4, 0, "R10"); tick(4);
    p2_in = 0; hs_src = 0; tick(4);

    // R12 external blanking
    set_cfg(8'h80);
    p2_in = 1; expect_at(2, 6, 1, "R12"); tick(4);
    p2_in = 0; expect_at(2, 6, 0, "R12"); tick(4);
    set_cfg(8'hA0); expect_at(3, 6, 1, "R12"); tick(4);

    // R13 outputs ignore input edges
    set_cfg(8'h14); tick(4);
    p1_in = 1; expect_at(2, 4, 0, "R13"); expect_at(3, 4, 0, "R13"); tick(4);
    hs_src = 1; p2_in = 1; expect_at(2, 4, 0, "R13"); expect_at(2, 5, 0, "R13"); tick(4);

    tick(3);
    if (q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule